// File: doc/BRIEF.md
# Page bit-17 swizzle fix-up engine

This engine keeps one history bit per page of a memory object, holding bit 17 of the physical address that page had when the history was last taken. It takes two commands. A save command walks the object's pages and copies each page's current physical bit 17 into its history bit. A restore command walks the pages again after they may have moved. Each page whose current physical bit 17 no longer matches its history bit is rewritten in place: within every 128-byte chunk, the lower 64 bytes and the upper 64 bytes trade places. The page is then reported as dirty.

Physical page frames come from a combinational lookup port that is indexed by page number. Memory is reached through a single 32-bit word port with a request/acknowledge handshake, and only one access is outstanding at a time. A rewrite reads all 32 words of a chunk into an internal buffer and then writes them back with the two halves exchanged. The number of pages is the object size in bytes divided by 4096, rounded down. It is limited to the depth of the history store.

Top module: `page_b17_fixer`

## Requirements
- R1: The page count is floor(obj_size / 4096), capped at MAX_PAGES (default 16). Only pages 0 to count-1 are visited, in ascending order, and a count of zero finishes with no page visited.
- R2: A save sets the history bit of each visited page to bit 17 of its physical address, which is bit 5 of the frame on `lk_pfn`. It makes no memory access and gives no dirty pulse.
- R3: A restore issued when no save has completed since reset makes no memory access and gives no dirty pulse. It only finishes with a done pulse.
- R4: A restore rewrites a page only when that page's current physical bit 17 differs from its history bit. The rewrite uses the frame that `lk_pfn` returns for that page's index. Pages that are not rewritten receive no memory access.
- R5: A rewrite covers every 128-byte chunk of the page. After it, the word at byte offset k (0 to 63) of each chunk holds the value that was at k+64, and the word at k+64 holds the value that was at k. A second identical restore therefore brings the page back to its earlier content.
- R6: `dirty_vld` is high for exactly one cycle after the last write of a rewritten page is acknowledged, with `dirty_idx` equal to that page's index. Pages are reported in the order they are rewritten.
- R7: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack` is seen. Addresses are word aligned, and `mem_req` is low during reset and when idle.
- R8: `busy` rises in the cycle after a command is accepted and stays high through the final cycle, in which `done` pulses for one cycle. `busy` is low in the next cycle, and both are low after reset.
- R9: A command presented while `busy` is high is ignored. It does not change the history bits or the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_save | input | 1 | Start a save (sampled while idle) |
| cmd_restore | input | 1 | Start a restore (sampled while idle; save wins if both are set) |
| obj_size | input | 32 | Object size in bytes, sampled with the command |
| lk_idx | output | 4 | Page index being looked up |
| lk_pfn | input | 20 | Physical frame number of page `lk_idx` (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes in a cycle where `mem_req` and `mem_ack` are both high |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse in the last busy cycle |
| dirty_vld | output | 1 | One-cycle pulse: a page was rewritten |
| dirty_idx | output | 4 | Index of the rewritten page |

## Verification
The assertions check the following on every cycle: the handshake hold rule, silence on the memory port and the dirty output while idle, `busy` rising only after a command, `busy` falling right after `done`, a dirty pulse lasting one cycle and directly following an acknowledged write, and a steady lookup index during memory traffic. Several behaviours can only be shown by the bench scenarios. These are which pages get rewritten given the saved history, the exchanged data in each chunk, the dropping of a partial last page, the cap on the page count, and a command arriving mid-run leaving the history untouched. The bench's memory model checks each write value against a snapshot taken at command start, and it checks each dirty report against the page list predicted by its own history model.

// File: rtl/page_b17_fixer.sv
module page_b17_fixer #(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int MAX_PAGES  = 16,
  parameter int SWZ_BIT    = 17,
  localparam int IDX_W     = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1,
  localparam int PFN_W     = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_save,
  input  logic              cmd_restore,
  input  logic [SIZE_W-1:0] obj_size,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic [PFN_W-1:0]  lk_pfn,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              dirty_vld,
  output logic [IDX_W-1:0]  dirty_idx
);
  localparam int CNT_W  = IDX_W + 1;
  localparam int CH_W   = PAGE_SHIFT - 7;
  localparam int WD_W   = 5;
  localparam int NWORDS = 1 << WD_W;
  localparam int SWZ_IN = SWZ_BIT - PAGE_SHIFT;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_RD, S_WR, S_FIN} st_t;

  st_t                  st_q;
  logic                 save_q, have_rec_q, dv_q;
  logic [MAX_PAGES-1:0] rec_q;
  logic [IDX_W-1:0]     idx_q, di_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [PFN_W-1:0]     pfn_q;
  logic [CH_W-1:0]      ch_q;
  logic [WD_W-1:0]      wd_q;
  logic [31:0]          hold_q [NWORDS];

  logic [SIZE_W-1:0] npg;
  logic [CNT_W-1:0]  cnt_in;
  logic              start, last_pg, flip, last_wd, last_ch;

  assign npg     = obj_size >> PAGE_SHIFT;
  assign cnt_in  = (npg > SIZE_W'(MAX_PAGES)) ? CNT_W'(MAX_PAGES) : npg[CNT_W-1:0];
  assign start   = (st_q == S_IDLE) && (cmd_save || cmd_restore);
  assign last_pg = ({1'b0, idx_q} == cnt_q - CNT_W'(1));
  assign flip    = lk_pfn[SWZ_IN] != rec_q[idx_q];
  assign last_wd = &wd_q;
  assign last_ch = &ch_q;

  assign lk_idx    = idx_q;
  assign mem_req   = (st_q == S_RD) || (st_q == S_WR);
  assign mem_we    = (st_q == S_WR);
  assign mem_addr  = {pfn_q, ch_q, wd_q, 2'b00};
  assign mem_wdata = hold_q[{~wd_q[WD_W-1], wd_q[WD_W-2:0]}];
  assign busy      = (st_q != S_IDLE);
  assign done      = (st_q == S_FIN);
  assign dirty_vld = dv_q;
  assign dirty_idx = di_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      save_q     <= 1'b0;
      have_rec_q <= 1'b0;
      rec_q      <= '0;
      idx_q      <= '0;
      cnt_q      <= '0;
      pfn_q      <= '0;
      ch_q       <= '0;
      wd_q       <= '0;
      dv_q       <= 1'b0;
      di_q       <= '0;
    end else begin
      dv_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          save_q <= cmd_save;
          idx_q  <= '0;
          cnt_q  <= cnt_in;
          if (cmd_save) have_rec_q <= 1'b1;
          st_q <= ((!cmd_save && !have_rec_q) || cnt_in == '0) ? S_FIN : S_LOOK;
        end
        S_LOOK: begin
          if (save_q) rec_q[idx_q] <= lk_pfn[SWZ_IN];
          if (!save_q && flip) begin
            pfn_q <= lk_pfn;
            ch_q  <= '0;
            wd_q  <= '0;
            st_q  <= S_RD;
          end else if (last_pg) begin
            st_q <= S_FIN;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_RD: if (mem_ack) begin
          wd_q <= wd_q + 1'b1;
          if (last_wd) st_q <= S_WR;
        end
        S_WR: if (mem_ack) begin
          wd_q <= wd_q + 1'b1;
          if (last_wd) begin
            ch_q <= ch_q + 1'b1;
            if (!last_ch) begin
              st_q <= S_RD;
            end else begin
              dv_q <= 1'b1;
              di_q <= idx_q;
              if (last_pg) begin
                st_q <= S_FIN;
              end else begin
                idx_q <= idx_q + 1'b1;
                st_q  <= S_LOOK;
              end
            end
          end
        end
        S_FIN:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == S_RD && mem_ack) hold_q[wd_q] <= mem_rdata;
  end
endmodule

// File: rtl/page_b17_fixer_chk.sv
module page_b17_fixer_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_save,
  input logic              cmd_restore,
  input logic [IDX_W-1:0]  lk_idx,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic              busy,
  input logic              done,
  input logic              dirty_vld
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !dirty_vld && !done);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_save || cmd_restore));

  // R8
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !done);

  // R6
  dirty_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_vld |=> !dirty_vld);

  // R6
  dirty_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_vld |-> $past(mem_req && mem_ack && mem_we));

  // R4
  lookup_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) |-> $stable(lk_idx));
endmodule

bind page_b17_fixer page_b17_fixer_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_save(cmd_save), .cmd_restore(cmd_restore),
  .lk_idx(lk_idx), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .busy(busy), .done(done),
  .dirty_vld(dirty_vld)
);

// File: tb/sim_page_b17_fixer.sv
module sim_page_b17_fixer;
  localparam int CLK_PERIOD = 10;
  localparam int PG = 4096;
  localparam int NP = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n, cmd_save, cmd_restore;
  logic [31:0] obj_size;
  logic [3:0]  lk_idx, dirty_idx;
  logic [19:0] lk_pfn;
  logic        mem_req, mem_we, mem_ack, busy, done, dirty_vld;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  page_b17_fixer u0 (
    .clk(clk), .rst_n(rst_n), .cmd_save(cmd_save), .cmd_restore(cmd_restore),
    .obj_size(obj_size), .lk_idx(lk_idx), .lk_pfn(lk_pfn),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .dirty_vld(dirty_vld), .dirty_idx(dirty_idx)
  );

  logic [19:0] phys_tab [NP];
  assign lk_pfn = phys_tab[lk_idx];

  logic [31:0] mem  [logic [31:0]];
  logic [31:0] pre  [logic [31:0]];
  logic [31:0] orig [logic [31:0]];

  int checks = 0, errors = 0;
  bit finished = 0;

  bit mrec [NP];
  bit mrec_ok = 0;
  bit swap_pg [NP];
  int pg_wr [NP];
  int exp_dirty [$];
  int cnt_m = 0, acc = 0, exp_acc = 0, done_cnt = 0;

  function automatic logic [31:0] seed_val(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A17C3E1;
  endfunction
  function automatic logic [31:0] mem_rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : seed_val(a);
  endfunction
  function automatic logic [31:0] pre_rd(logic [31:0] a);
    return pre.exists(a) ? pre[a] : seed_val(a);
  endfunction
  function automatic logic [31:0] orig_rd(logic [31:0] a);
    return orig.exists(a) ? orig[a] : seed_val(a);
  endfunction
  function automatic int page_of(logic [31:0] a);
    for (int i = 0; i < NP; i++) if (phys_tab[i] == a[31:12]) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_phys(logic [15:0] pat);
    for (int i = 0; i < NP; i++)
      phys_tab[i] = 20'h01000 + 20'(i << 6) + (pat[i] ? 20'h00020 : 20'h0);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) mem_rdata <= mem_rd(mem_addr);
      if (mem_req && mem_ack && mem_we) mem[mem_addr] = mem_wdata;
    end
  end

  always @(negedge clk) begin
    int p, e;
    if (rst_n) begin
      if (mem_req && mem_ack) begin
        acc++;
        p = page_of(mem_addr);
        chk(mem_addr[1:0] == 2'b00, "R7 word aligned address", mem_addr[1:0], 0);
        if (p < 0 || p >= cnt_m || !swap_pg[p]) begin
          chk(0, "R4 access outside a page due for rewrite", mem_addr, 0);
        end else if (mem_we) begin
          pg_wr[p]++;
          chk(mem_wdata == pre_rd(mem_addr ^ 32'h40), "R5 exchanged word value",
              mem_wdata, pre_rd(mem_addr ^ 32'h40));
        end
      end
      if (dirty_vld) begin
        if (exp_dirty.size() == 0) begin
          chk(0, "R6 unexpected dirty report", dirty_idx, 0);
        end else begin
          e = exp_dirty.pop_front();
          chk(int'(dirty_idx) == e, "R6 dirty page index", dirty_idx, e);
          chk(pg_wr[e] == 1024, "R6 dirty after all page writes", pg_wr[e], 1024);
        end
      end
      if (done) done_cnt++;
    end
  end

  task automatic run(bit save, int size, int poke_at, string tag);
    int nsw = 0;
    int cyc = 0;
    cnt_m = size / PG;
    if (cnt_m > NP) cnt_m = NP;
    exp_dirty.delete();
    for (int i = 0; i < NP; i++) begin
      swap_pg[i] = 0;
      pg_wr[i] = 0;
    end
    if (!save && mrec_ok)
      for (int i = 0; i < cnt_m; i++)
        if (phys_tab[i][5] != mrec[i]) begin
          swap_pg[i] = 1;
          exp_dirty.push_back(i);
          nsw++;
        end
    exp_acc = nsw * 2048;
    pre = mem;
    acc = 0;
    done_cnt = 0;
    obj_size = size;
    cmd_save = save;
    cmd_restore = !save;
    @(negedge clk);
    cmd_save = 0;
    cmd_restore = 0;
    chk(busy == 1'b1, "R8 busy after accepted command", busy, 1);
    while (!done) begin
      @(negedge clk);
      cyc++;
      cmd_save = (cyc == poke_at);
      if (cyc == poke_at) obj_size = NP * PG;
    end
    cmd_save = 0;
    @(negedge clk);
    chk(busy == 1'b0, "R8 busy low after done", busy, 0);
    chk(done == 1'b0, "R8 done lasts one cycle", done, 0);
    chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
    chk(acc == exp_acc, tag, acc, exp_acc);
    chk(exp_dirty.size() == 0, "R6 all expected dirty reports seen", exp_dirty.size(), 0);
    if (save) begin
      for (int i = 0; i < cnt_m; i++) mrec[i] = phys_tab[i][5];
      mrec_ok = 1;
    end
  endtask

  initial begin
    rst_n = 0;
    cmd_save = 0;
    cmd_restore = 0;
    obj_size = 0;
    set_phys(16'h0000);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R8 busy in reset", busy, 0);
    chk(done == 1'b0, "R8 done in reset", done, 0);
    chk(dirty_vld == 1'b0, "R6 dirty in reset", dirty_vld, 0);
    chk(mem_req == 1'b0, "R7 req in reset", mem_req, 0);
    rst_n = 1;
    @(negedge clk);

    set_phys(16'h0005);
    run(0, 4*PG, 0, "R3 restore with no record");
    run(1, 4*PG, 0, "R2 save makes no access");

    set_phys(16'h0003);
    orig = mem;
    run(0, 4*PG, 0, "R4 restore rewrites pages 1 and 2");
    chk(mem_rd({phys_tab[1], 12'h000}) == orig_rd({phys_tab[1], 12'h040}), "R5 page 1 low half",
        mem_rd({phys_tab[1], 12'h000}), orig_rd({phys_tab[1], 12'h040}));
    chk(mem_rd({phys_tab[2], 12'hFFC}) == orig_rd({phys_tab[2], 12'hFBC}), "R5 page 2 last word",
        mem_rd({phys_tab[2], 12'hFFC}), orig_rd({phys_tab[2], 12'hFBC}));
    run(0, 4*PG, 0, "R4 second restore rewrites again");
    chk(mem_rd({phys_tab[1], 12'h040}) == orig_rd({phys_tab[1], 12'h040}), "R5 double exchange restores",
        mem_rd({phys_tab[1], 12'h040}), orig_rd({phys_tab[1], 12'h040}));
    chk(mem_rd({phys_tab[2], 12'h7C4}) == orig_rd({phys_tab[2], 12'h7C4}), "R5 double exchange restores",
        mem_rd({phys_tab[2], 12'h7C4}), orig_rd({phys_tab[2], 12'h7C4}));

    set_phys(16'h000D);
    run(0, 3*PG + 100, 0, "R1 partial last page dropped");
    run(0, 0, 0, "R1 zero pages");
    run(0, 4*PG, 0, "R4 only page 3 differs");

    set_phys(16'h0000);
    run(1, 40*PG, 0, "R1 save capped at sixteen pages");
    set_phys(16'h8000);
    run(0, 40*PG, 0, "R1 restore reaches page 15");

    set_phys(16'h0001);
    run(0, 16*PG, 50, "R9 command while busy ignored");
    run(0, 16*PG, 0, "R9 history untouched by ignored save");

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule